// File: doc/BRIEF.md
# Packet Receive Register Window

This block sits between a 32-bit AXI4-Stream carrying received packets and a processor that reads them through a small register window. Incoming beats are written into a store-and-forward ring buffer. A packet becomes visible to the register side only once its final beat has been stored, so its byte count is already known when software first sees it.

Software works on the beat at the head of the buffer. The metadata word shows that beat's byte strobe, end-of-packet flag and port bytes, and can be read any number of times. The data word returns the beat's payload with the first stream byte in the most significant position, and reading it removes the beat. The length word reports the packet's byte count only while the head beat opens a packet, so software can tell a packet start from the middle of one and can resynchronise.

When the buffer is full of complete packets the stream input stalls. A single packet with more beats than the buffer holds can never be stored; it is discarded whole and a saturating drop counter is incremented.

Top module: `pkt_rx_window`

## Requirements
- R1: Reads use byte offsets on `rd_addr`: 0x0 selects the data word, 0x4 the metadata word and 0x8 the length word; `rd_data` holds the result from the cycle after `rd_en` until the next read.
- R2: The metadata word carries the head beat's destination port (`s_tuser[15:8]`) in bits 31:24, source port (`s_tuser[7:0]`) in bits 23:16, end-of-packet flag in bit 7 and its byte strobe (`s_tkeep`) in bits 3:0; all other bits are zero.
- R3: Reading the metadata word never removes the head beat; repeated reads return the same value.
- R4: Reading the data word returns the head beat's payload with stream byte lane 0 (`s_tdata[7:0]`) in bits 31:24 down to lane 3 in bits 7:0, and removes that beat.
- R5: The length word equals the sum of set strobe bits over all beats of the head packet while the head beat is that packet's first beat, and reads zero at every later beat.
- R6: With no complete packet buffered, metadata, length and data reads all return zero and a data read changes nothing.
- R7: No beat of a packet is visible (metadata strobe zero) until the beat carrying `s_tlast` has been accepted.
- R8: `s_tready` is low when all DEPTH entries hold beats and at least one complete packet is among them.
- R9: A packet of more than DEPTH beats is accepted and discarded whole, later packets are delivered intact, and `drop_count` rises by one per such packet, saturating at its maximum.
- R10: After reset `s_tready` is high, `drop_count` is zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted when high with valid |
| s_tdata | input | 32 | Stream payload, lane 0 in bits 7:0 |
| s_tkeep | input | 4 | Byte strobe, contiguous from lane 0 |
| s_tlast | input | 1 | Final beat of a packet |
| s_tuser | input | 16 | Destination port in 15:8, source port in 7:0 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register byte offset |
| rd_data | output | 32 | Registered read result |
| drop_count | output | DROP_W | Saturating count of oversized packets |

## Verification
The bench builds the block with DEPTH=4, LEN_W=8 and DROP_W=2, so one packet of four beats fills the ring and a five-beat packet overflows it. That brings every packet size from 1 to 16 bytes, and so every final-beat strobe, into a full sweep, and makes stalling, whole-packet dropping and drop counter saturation reachable after a few packets. Expected lengths, metadata words and byte-swapped data words are computed arithmetically from the byte sequence the bench sends.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam logic [3:0] OFF_DATA = 4'h0;
  localparam logic [3:0] OFF_META = 4'h4;
  localparam logic [3:0] OFF_LEN  = 4'h8;

  typedef struct packed {
    logic [31:0] data;
    logic [3:0]  keep;
    logic        last;
    logic [7:0]  dst;
    logic [7:0]  src;
  } beat_t;

  // Number of bytes a beat contributes.
  function automatic logic [2:0] keep_bytes(input logic [3:0] k);
    return 3'(k[0]) + 3'(k[1]) + 3'(k[2]) + 3'(k[3]);
  endfunction

  // Lane 0 moves to the most significant byte.
  function automatic logic [31:0] to_big_endian(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] pack_meta(input beat_t b);
    return {b.dst, b.src, 8'h00, b.last, 3'b000, b.keep};
  endfunction

endpackage

// File: rtl/pkt_rx_lenq.sv
module pkt_rx_lenq #(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
endmodule

// File: rtl/pkt_rx_store.sv
module pkt_rx_store
  import pkt_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  beat_t            in_beat,
  output logic             commit,
  output logic [LEN_W-1:0] commit_len,
  output logic             drop_evt,
  output logic             dropping,
  output logic             full,
  input  logic             pop,
  output beat_t            head,
  output logic             avail
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  beat_t            mem [DEPTH];
  logic [AW:0]      wr_ptr, cmt_ptr, rd_ptr;
  logic [LEN_W-1:0] len_acc;
  logic             accept, over, wr_fire;
  logic [AW:0]      used, pending;

  assign used     = wr_ptr - rd_ptr;
  assign pending  = wr_ptr - cmt_ptr;
  assign full     = (used == CAP);
  // The open packet alone fills the ring: it can never complete.
  assign over     = full && (pending == CAP);
  assign in_ready = dropping || !full || over;
  assign accept   = in_valid && in_ready;
  assign wr_fire  = accept && !over && !dropping;
  assign drop_evt = accept && over;

  assign commit     = wr_fire && in_beat.last;
  assign commit_len = len_acc + LEN_W'(keep_bytes(in_beat.keep));

  assign avail = (rd_ptr != cmt_ptr);
  assign head  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      cmt_ptr  <= '0;
      rd_ptr   <= '0;
      len_acc  <= '0;
      dropping <= 1'b0;
    end else begin
      if (pop && avail) rd_ptr <= rd_ptr + 1'b1;
      if (drop_evt) begin
        wr_ptr   <= cmt_ptr;
        len_acc  <= '0;
        dropping <= !in_beat.last;
      end else if (accept && dropping) begin
        if (in_beat.last) dropping <= 1'b0;
      end else if (wr_fire) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (in_beat.last) begin
          cmt_ptr <= wr_ptr + 1'b1;
          len_acc <= '0;
        end else begin
          len_acc <= commit_len;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= in_beat;
  end
endmodule

// File: rtl/pkt_rx_window.sv
module pkt_rx_window
  import pkt_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [31:0]       s_tdata,
  input  logic [3:0]        s_tkeep,
  input  logic              s_tlast,
  input  logic [15:0]       s_tuser,
  input  logic              rd_en,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic [DROP_W-1:0] drop_count
);
  beat_t            in_beat, head_beat;
  logic             commit, drop_evt, dropping, buf_full, head_valid;
  logic [LEN_W-1:0] commit_len, len_head;
  logic             head_first, pop_fire, last_pop;

  assign in_beat = '{data: s_tdata, keep: s_tkeep, last: s_tlast,
                     dst: s_tuser[15:8], src: s_tuser[7:0]};

  assign pop_fire = rd_en && (rd_addr == OFF_DATA) && head_valid;
  assign last_pop = pop_fire && head_beat.last;

  pkt_rx_store #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_store (
    .clk, .rst_n,
    .in_valid(s_tvalid), .in_ready(s_tready), .in_beat,
    .commit, .commit_len, .drop_evt, .dropping, .full(buf_full),
    .pop(pop_fire), .head(head_beat), .avail(head_valid)
  );

  pkt_rx_lenq #(.DEPTH(DEPTH), .W(LEN_W)) u_lenq (
    .clk, .rst_n, .push(commit), .din(commit_len),
    .pop(last_pop), .dout(len_head)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_first <= 1'b1;
      drop_count <= '0;
      rd_data    <= '0;
    end else begin
      if (pop_fire) head_first <= head_beat.last;
      if (drop_evt && (drop_count != '1)) drop_count <= drop_count + 1'b1;
      if (rd_en) begin
        unique case (rd_addr)
          OFF_DATA: rd_data <= head_valid ? to_big_endian(head_beat.data) : '0;
          OFF_META: rd_data <= head_valid ? pack_meta(head_beat) : '0;
          OFF_LEN:  rd_data <= (head_valid && head_first) ? 32'(len_head) : '0;
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_rx_window_chk.sv
module pkt_rx_window_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tready,
  input logic              rd_en,
  input logic [3:0]        rd_addr,
  input logic [31:0]       rd_data,
  input logic [DROP_W-1:0] drop_count,
  input logic              head_valid,
  input logic              head_first,
  input logic              dropping,
  input logic              buf_full
);
  // R6
  empty_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'h0 && !head_valid) |=> (rd_data == 32'h0));

  // R3
  meta_peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'h4 && head_valid) |=> head_valid);

  // R5
  len_mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'h8 && !head_first) |=> (rd_data == 32'h0));

  // R2
  meta_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'h4) |=> (rd_data[15:8] == 8'h0 && rd_data[6:4] == 3'h0));

  // R9
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));

  // R8
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_tready |-> (buf_full && !dropping));
endmodule

bind pkt_rx_window pkt_rx_window_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tready(s_tready), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .drop_count(drop_count),
  .head_valid(head_valid), .head_first(head_first),
  .dropping(dropping), .buf_full(buf_full)
);

// File: tb/pkt_rx_window_test.sv
`timescale 1ns/1ps
module pkt_rx_window_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_tvalid = 1'b0, s_tlast = 1'b0, rd_en = 1'b0;
  logic        s_tready;
  logic [31:0] s_tdata = '0, rd_data;
  logic [3:0]  s_tkeep = '0, rd_addr = '0;
  logic [15:0] s_tuser = '0;
  logic [1:0]  drop_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_rx_window #(.DEPTH(DEPTH), .LEN_W(8), .DROP_W(2)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  function automatic logic [7:0] byte_at(input int base, input int idx);
    return 8'((base + idx) & 255);
  endfunction

  task automatic send_beat(input int base, input int bt, input int n,
                           input logic [7:0] dst, input logic [7:0] src);
    int rem = n - bt * 4;
    int vb = (rem > 4) ? 4 : rem;
    @(negedge clk);
    s_tdata = '0; s_tkeep = '0;
    for (int i = 0; i < vb; i++) begin
      s_tdata[8*i +: 8] = byte_at(base, bt*4 + i);
      s_tkeep[i] = 1'b1;
    end
    s_tlast = (rem <= 4); s_tuser = {dst, src}; s_tvalid = 1'b1;
    while (!s_tready) @(negedge clk);
    @(posedge clk); #1 s_tvalid = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [7:0] dst, input logic [7:0] src, input int base);
    for (int b = 0; b < (n + 3) / 4; b++) send_beat(base, b, n, dst, src);
  endtask

  task automatic drain_pkt(input int n, input logic [7:0] dst, input logic [7:0] src, input int base);
    logic [31:0] v, m;
    int nb = (n + 3) / 4;
    rd(4'h8, v); chk("R5 length on first beat", v, 32'(n));
    for (int b = 0; b < nb; b++) begin
      int rem = n - b*4;
      int vb = (rem > 4) ? 4 : rem;
      logic [31:0] em = (32'(dst) << 24) | (32'(src) << 16) |
                        ((b == nb-1) ? 32'h80 : 32'h0) | 32'((1 << vb) - 1);
      logic [31:0] ed = '0;
      for (int i = 0; i < vb; i++) ed[31 - 8*i -: 8] = byte_at(base, b*4 + i);
      rd(4'h4, m); chk("R2 metadata layout", m, em);
      rd(4'h4, v); chk("R3 metadata peek repeat", v, m);
      if (b > 0) begin
        rd(4'h8, v); chk("R5 length zero mid packet", v, 32'h0);
      end
      rd(4'h0, v); chk("R4 big-endian data pop", v, ed);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 tready after reset", 32'(s_tready), 32'h1);
    chk("R10 drop_count after reset", 32'(drop_count), 32'h0);
    rd(4'h4, v); chk("R6 R10 empty metadata", v, 32'h0);
    rd(4'h8, v); chk("R6 empty length", v, 32'h0);
    rd(4'h0, v); chk("R6 empty data read", v, 32'h0);
    rd(4'h4, v); chk("R6 empty data read no effect", v, 32'h0);

    // R1 R2 R4 R5 sweep over every size that fits
    for (int n = 1; n <= 4*DEPTH; n++) begin
      send_pkt(n, 8'(n + 8'h40), 8'(8'h10 + n), n * 7);
      drain_pkt(n, 8'(n + 8'h40), 8'(8'h10 + n), n * 7);
      rd(4'h4, v); chk("R6 empty after drain", v, 32'h0);
    end

    // Two packets queued back to back, drained in order
    send_pkt(6, 8'h01, 8'h02, 100);
    send_pkt(3, 8'h03, 8'h04, 200);
    drain_pkt(6, 8'h01, 8'h02, 100);
    drain_pkt(3, 8'h03, 8'h04, 200);

    // R7 store-and-forward visibility
    send_beat(50, 0, 7, 8'hA1, 8'hB2);
    rd(4'h4, v); chk("R7 open packet hidden", v, 32'h0);
    send_beat(50, 1, 7, 8'hA1, 8'hB2);
    drain_pkt(7, 8'hA1, 8'hB2, 50);

    // R8 stall while full of a complete packet
    send_pkt(16, 8'h11, 8'h22, 30);
    @(negedge clk);
    s_tdata = 32'h12345678; s_tkeep = 4'hF; s_tlast = 1'b1; s_tvalid = 1'b1;
    #0.5 chk("R8 tready low when full", 32'(s_tready), 32'h0);
    @(negedge clk); s_tvalid = 1'b0;
    drain_pkt(16, 8'h11, 8'h22, 30);
    chk("R8 tready back after drain", 32'(s_tready), 32'h1);

    // R9 oversized packets dropped whole, counter saturates
    send_pkt(17, 8'h55, 8'h66, 9);
    @(negedge clk);
    chk("R9 drop count one", 32'(drop_count), 32'h1);
    rd(4'h4, v); chk("R9 dropped packet invisible", v, 32'h0);
    send_pkt(5, 8'h77, 8'h88, 60);
    drain_pkt(5, 8'h77, 8'h88, 60);
    send_pkt(32, 8'h55, 8'h66, 1);
    send_pkt(20, 8'h55, 8'h66, 2);
    @(negedge clk);
    chk("R9 drop count three", 32'(drop_count), 32'h3);
    send_pkt(25, 8'h55, 8'h66, 3);
    @(negedge clk);
    chk("R9 drop count saturates", 32'(drop_count), 32'h3);
    send_pkt(13, 8'h9A, 8'hBC, 77);
    drain_pkt(13, 8'h9A, 8'hBC, 77);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule